// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block sits between a simple 32-bit register bus and a raw NAND flash device. Software places a command byte, an address byte or a data byte on the flash pins by writing one of three registers. Reading the data register fetches one byte from the flash. Each such access becomes one flash bus cycle. The cycle has three phases: a setup phase with the latch lines and data valid and the strobe high, a strobe-low phase, and a hold phase with the strobe high again and the lines still driven. The length of each phase comes from a field in a shared configuration word.

The same configuration word holds the controller enable, the chip-enable level and a self-clearing bit that restarts an external ECC accumulator. A status register returns the flash ready/busy line after a two-flop synchronizer. Register accesses are acknowledged one cycle after they are presented. Flash cycles hold the acknowledge back until the hold phase has finished, so software never has to poll for cycle completion. The 8-bit flash data bus is brought out as separate output, output-enable and input pins, so the pad ring can build the bidirectional buffer.

Register byte offsets: configuration 0x00, command 0x04, address 0x08, data 0x0C, status 0x10. Offset 0x14 is kept for an ECC result and reads zero.

Top module: `nand_cycle_seq`

## Requirements
- R1: Reset leaves every output idle: fl_ce_n=1, fl_we_n=1, fl_re_n=1, fl_cle=0, fl_ale=0, fl_dq_oe=0, bus_ack=0, ecc_init=0. The configuration register then reads 0x0000_0B77: disabled, chip deselected, all timing fields at their maximum.
- R2: The configuration register fields are: enable at bit 15, chip-enable level at bit 11, setup length minus one at bits 9:8, strobe length minus one at bits 6:4, hold length minus one at bits 2:0. All other bits read zero, so writing all ones reads back 0x0000_8B77.
- R3: With field values S, W and H, every flash cycle runs S+1 setup cycles with both strobes high, then W+1 cycles with the strobe low, then H+1 hold cycles with both strobes high. Writes pulse fl_we_n and reads pulse fl_re_n.
- R4: A command-register write holds fl_cle high, and an address-register write holds fl_ale high, for all S+W+H+3 cycles of the flash cycle. A data-register access raises neither line.
- R5: A write cycle drives bus_wdata[7:0] on fl_dq_o with fl_dq_oe high for the whole flash cycle. A read cycle keeps fl_dq_oe low.
- R6: A data-register read samples fl_dq_i at the clock edge where fl_re_n rises. It returns that byte in bus_rdata[7:0], with the upper bits zero, while bus_ack is high.
- R7: bus_ack is a one-cycle pulse. A flash-cycle access receives it in the cycle after the hold phase, that is S+W+H+4 cycles after the access is first presented. Other register accesses receive it in the next cycle.
- R8: With the enable bit clear, command, address and data accesses are acknowledged in the next cycle with no strobe or latch activity, and a data read returns zero.
- R9: fl_ce_n follows configuration bit 11 from the cycle after the write: 1 deselects the chip, 0 selects it.
- R10: Writing 1 to configuration bit 12 produces a single one-cycle pulse on ecc_init, and the bit always reads back 0.
- R11: Status bit 0 returns fl_rdy (1 ready, 0 busy) through a two-flop synchronizer. A status read presented one cycle after fl_rdy changes still returns the old level, and one presented three cycles after the change returns the new level.
- R12: Reads of offset 0x14 and of the command and address registers return zero and start no flash cycle. Writes to 0x14 leave the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request, held until bus_ack |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Flash data output enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_rdy | input | 1 | Flash ready (1) / busy (0) |
| ecc_init | output | 1 | One-cycle pulse restarting the external ECC accumulator |

## Verification
A wrong phase counter or a wrong state decision shows up in the cycle counts as a setup, strobe or hold phase that is one cycle too long or too short. A stuck sequencer shows up as an acknowledge that never arrives. Both are visible at the pins within the same access, no more than 28 cycles after the request. A wrong latch-line or output-enable decision is visible in the first cycle after acceptance. Read capture on the wrong edge is exposed because the bench drives a different byte whenever fl_re_n is high. Removing or shortening the ready synchronizer shows up as a changed status value one cycle after fl_rdy moves.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int HBUS_W  = 32;
  localparam int HADDR_W = 5;
  localparam int FBYTE_W = 8;

  // timing field widths and positions in the configuration word
  localparam int SET_W   = 2;
  localparam int STB_W   = 3;
  localparam int HLD_W   = 3;
  localparam int SET_LSB = 8;
  localparam int STB_LSB = 4;
  localparam int HLD_LSB = 0;
  localparam int EN_BIT  = 15;
  localparam int ECC_BIT = 12;
  localparam int CE_BIT  = 11;

  localparam int CNT_W = (SET_W > STB_W) ? ((SET_W > HLD_W) ? SET_W : HLD_W)
                                         : ((STB_W > HLD_W) ? STB_W : HLD_W);

  localparam logic [HADDR_W-1:0] REG_CFG = 5'h00;
  localparam logic [HADDR_W-1:0] REG_CMD = 5'h04;
  localparam logic [HADDR_W-1:0] REG_ADR = 5'h08;
  localparam logic [HADDR_W-1:0] REG_DAT = 5'h0C;
  localparam logic [HADDR_W-1:0] REG_STS = 5'h10;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;
  typedef enum logic [1:0] {OP_CMD, OP_ADR, OP_WR, OP_RD} xfer_e;

  typedef struct packed {
    logic [SET_W-1:0] setup;
    logic [STB_W-1:0] strobe;
    logic [HLD_W-1:0] hold;
  } timing_t;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/nand_cfg_regs.sv
module nand_cfg_regs
  import nand_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [HBUS_W-1:0] wdata,
  output logic              en,
  output logic              ce_n,
  output logic              ecc_init,
  output timing_t           tm,
  output logic [HBUS_W-1:0] cfg_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      ce_n     <= 1'b1;
      ecc_init <= 1'b0;
      tm       <= '1;
    end else begin
      ecc_init <= wr_en & wdata[ECC_BIT];
      if (wr_en) begin
        en        <= wdata[EN_BIT];
        ce_n      <= wdata[CE_BIT];
        tm.setup  <= wdata[SET_LSB +: SET_W];
        tm.strobe <= wdata[STB_LSB +: STB_W];
        tm.hold   <= wdata[HLD_LSB +: HLD_W];
      end
    end
  end

  always_comb begin
    cfg_word                   = '0;
    cfg_word[EN_BIT]           = en;
    cfg_word[CE_BIT]           = ce_n;
    cfg_word[SET_LSB +: SET_W] = tm.setup;
    cfg_word[STB_LSB +: STB_W] = tm.strobe;
    cfg_word[HLD_LSB +: HLD_W] = tm.hold;
  end
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  xfer_e              op,
  input  logic [FBYTE_W-1:0] byte_i,
  input  timing_t            tm,
  input  logic [FBYTE_W-1:0] dq_i,
  output logic               cle,
  output logic               ale,
  output logic               we_n,
  output logic               re_n,
  output logic               dq_oe,
  output logic [FBYTE_W-1:0] dq_o,
  output logic [FBYTE_W-1:0] rd_byte,
  output logic               done,
  output logic               busy
);
  phase_e           ph;
  logic [CNT_W-1:0] cnt;
  logic             is_rd;

  assign busy = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      is_rd   <= 1'b0;
      cle     <= 1'b0;
      ale     <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      dq_oe   <= 1'b0;
      dq_o    <= '0;
      rd_byte <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph    <= PH_SETUP;
            cnt   <= CNT_W'(tm.setup);
            is_rd <= (op == OP_RD);
            cle   <= (op == OP_CMD);
            ale   <= (op == OP_ADR);
            dq_oe <= (op != OP_RD);
            dq_o  <= byte_i;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            ph  <= PH_STROBE;
            cnt <= CNT_W'(tm.strobe);
            if (is_rd) re_n <= 1'b0;
            else       we_n <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            ph   <= PH_HOLD;
            cnt  <= CNT_W'(tm.hold);
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (is_rd) rd_byte <= dq_i;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            ph    <= PH_IDLE;
            cle   <= 1'b0;
            ale   <= 1'b0;
            dq_oe <= 1'b0;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [HADDR_W-1:0] bus_addr,
  input  logic [HBUS_W-1:0]  bus_wdata,
  output logic [HBUS_W-1:0]  bus_rdata,
  output logic               bus_ack,
  output logic               fl_ce_n,
  output logic               fl_cle,
  output logic               fl_ale,
  output logic               fl_we_n,
  output logic               fl_re_n,
  output logic [FBYTE_W-1:0] fl_dq_o,
  output logic               fl_dq_oe,
  input  logic [FBYTE_W-1:0] fl_dq_i,
  input  logic               fl_rdy,
  output logic               ecc_init
);
  logic               en, rdy_s, seq_busy, seq_done, ack_q;
  logic               accept, seq_req, cfg_wr;
  logic               hit_cfg, hit_cmd, hit_adr, hit_dat, hit_sts;
  logic [HBUS_W-1:0]  cfg_word, rd_mux, rdata_q;
  logic [FBYTE_W-1:0] rd_byte;
  timing_t            tm;
  xfer_e              op;

  assign hit_cfg = (bus_addr == REG_CFG);
  assign hit_cmd = (bus_addr == REG_CMD);
  assign hit_adr = (bus_addr == REG_ADR);
  assign hit_dat = (bus_addr == REG_DAT);
  assign hit_sts = (bus_addr == REG_STS);

  assign accept  = bus_sel && !bus_ack && !seq_busy;
  assign seq_req = accept && en && ((bus_wr && (hit_cmd || hit_adr)) || hit_dat);
  assign cfg_wr  = accept && bus_wr && hit_cfg;
  assign op      = hit_cmd ? OP_CMD : (hit_adr ? OP_ADR : (bus_wr ? OP_WR : OP_RD));

  always_comb begin
    rd_mux = '0;
    if (hit_cfg)      rd_mux = cfg_word;
    else if (hit_sts) rd_mux = {{(HBUS_W-1){1'b0}}, rdy_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= accept && !seq_req;
      rdata_q <= (accept && !seq_req && !bus_wr) ? rd_mux : '0;
    end
  end

  assign bus_ack   = ack_q | seq_done;
  assign bus_rdata = seq_done ? HBUS_W'(rd_byte) : rdata_q;

  nand_cfg_regs u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr),
    .wdata    (bus_wdata),
    .en       (en),
    .ce_n     (fl_ce_n),
    .ecc_init (ecc_init),
    .tm       (tm),
    .cfg_word (cfg_word)
  );

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (fl_rdy),
    .sync_o  (rdy_s)
  );

  nand_phase_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (seq_req),
    .op      (op),
    .byte_i  (bus_wdata[FBYTE_W-1:0]),
    .tm      (tm),
    .dq_i    (fl_dq_i),
    .cle     (fl_cle),
    .ale     (fl_ale),
    .we_n    (fl_we_n),
    .re_n    (fl_re_n),
    .dq_oe   (fl_dq_oe),
    .dq_o    (fl_dq_o),
    .rd_byte (rd_byte),
    .done    (seq_done),
    .busy    (seq_busy)
  );
endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_ack,
  input logic       fl_cle,
  input logic       fl_ale,
  input logic       fl_we_n,
  input logic       fl_re_n,
  input logic       fl_dq_oe,
  input logic [7:0] fl_dq_o,
  input logic       ecc_init
);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_re_n));

  p_latch_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(fl_cle && fl_ale));

  p_wr_drives_r5: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> fl_dq_oe);

  p_rd_floats_r6: assert property (@(posedge clk) disable iff (rst)
    !fl_re_n |-> !fl_dq_oe);

  p_hold_data_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> $stable(fl_dq_o));

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  p_ack_idle_r7: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> (fl_we_n && fl_re_n && !fl_cle && !fl_ale));

  p_ecc_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    ecc_init |=> !ecc_init);
endmodule

bind nand_cycle_seq nand_cycle_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_ack  (bus_ack),
  .fl_cle   (fl_cle),
  .fl_ale   (fl_ale),
  .fl_we_n  (fl_we_n),
  .fl_re_n  (fl_re_n),
  .fl_dq_oe (fl_dq_oe),
  .fl_dq_o  (fl_dq_o),
  .ecc_init (ecc_init)
);

// File: tb/nand_cycle_seq_tb_top.sv
module nand_cycle_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack, fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe, ecc_init;
  logic [7:0]  fl_dq_o, fl_dq_i, rd_val = 8'h00;
  logic        fl_rdy = 1'b0;

  int checks = 0, errors = 0, cyc = 0;
  int m_ack, m_pre, m_low, m_post, m_cle, m_ale, m_oe, m_ecc;
  logic        m_dq_ok;
  logic [31:0] m_rd;

  // vector: [19:18] op (0 cmd,1 addr,2 wr data,3 rd data) [17:16] S [14:12] W [10:8] H [7:0] byte
  localparam logic [19:0] VEC [7] = '{20'h00070, 20'h37700, 20'h5205A, 20'hA04A5,
                                      20'hC313C, 20'hF77C3, 20'h800FF};

  always #2 clk = ~clk;

  assign fl_dq_i = fl_re_n ? ~rd_val : rd_val;

  nand_cycle_seq dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n),
    .fl_re_n(fl_re_n), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_rdy(fl_rdy), .ecc_init(ecc_init)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [4:0] a, input logic w, input logic [31:0] d);
    logic seen;
    seen = 1'b0;
    m_ack = 0; m_pre = 0; m_low = 0; m_post = 0; m_cle = 0; m_ale = 0; m_oe = 0; m_ecc = 0;
    m_dq_ok = 1'b1; m_rd = '0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      m_ack++;
      if (ecc_init) m_ecc++;
      if (bus_ack) begin
        m_rd = bus_rdata;
        break;
      end
      if (fl_cle) m_cle++;
      if (fl_ale) m_ale++;
      if (fl_dq_oe) m_oe++;
      if (!fl_we_n || !fl_re_n) begin
        m_low++;
        seen = 1'b1;
        if (!fl_we_n && fl_dq_o !== d[7:0]) m_dq_ok = 1'b0;
      end else if (seen) m_post++;
      else m_pre++;
    end
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++; checks++;
      $display("FAIL R7 watchdog act=hung exp=ack");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] e;
    int op, s, wv, h, tot;
    logic [7:0] b;
    logic [4:0] a;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the pins
    chk("R1 idle pins", {fl_ce_n, fl_we_n, fl_re_n, fl_cle, fl_ale, fl_dq_oe, bus_ack, ecc_init},
        8'b1110_0000);
    xfer(5'h00, 1'b0, 0);
    chk("R1 cfg reset value", m_rd, 32'h0000_0B77);
    xfer(5'h10, 1'b0, 0);
    chk("R1 status busy after reset", m_rd, 32'h0);

    // R2 field layout
    xfer(5'h00, 1'b1, 32'hFFFF_FFFF);
    xfer(5'h00, 1'b0, 0);
    chk("R2 all-ones readback", m_rd, 32'h0000_8B77);
    xfer(5'h00, 1'b1, 32'h0000_0235);
    xfer(5'h00, 1'b0, 0);
    chk("R2 mixed readback", m_rd, 32'h0000_0235);

    // R10 ECC restart pulse
    xfer(5'h00, 1'b1, 32'h0000_1000);
    chk("R10 ecc pulse seen", m_ecc, 1);
    chk("R7 register ack next cycle", m_ack, 1);
    @(negedge clk);
    chk("R10 ecc pulse single", {31'h0, ecc_init}, 0);
    xfer(5'h00, 1'b0, 0);
    chk("R10 bit reads zero", m_rd, 32'h0);

    // R9 chip enable
    chk("R9 ce selected", {31'h0, fl_ce_n}, 0);
    xfer(5'h00, 1'b1, 32'h0000_0800);
    chk("R9 ce deselected", {31'h0, fl_ce_n}, 1);

    // R8 disabled controller
    xfer(5'h04, 1'b1, 32'h90);
    chk("R8 disabled ack time", m_ack, 1);
    chk("R8 disabled no strobe", m_low, 0);
    chk("R8 disabled no cle", m_cle, 0);
    rd_val = 8'h77;
    xfer(5'h0C, 1'b0, 0);
    chk("R8 disabled read zero", m_rd, 0);
    chk("R8 disabled read no strobe", m_low, 0);

    // R11 ready synchronizer
    fl_rdy = 1'b1;
    repeat (3) @(negedge clk);
    xfer(5'h10, 1'b0, 0);
    chk("R11 ready seen", m_rd, 1);
    fl_rdy = 1'b0;
    xfer(5'h10, 1'b0, 0);
    chk("R11 sync delay keeps old", m_rd, 1);
    repeat (3) @(negedge clk);
    xfer(5'h10, 1'b0, 0);
    chk("R11 busy seen", m_rd, 0);

    // R12 unmapped and write-only registers
    xfer(5'h14, 1'b1, 32'hFFFF_FFFF);
    xfer(5'h00, 1'b0, 0);
    chk("R12 unmapped write ignored", m_rd, 32'h0000_0800);
    xfer(5'h14, 1'b0, 0);
    chk("R12 unmapped reads zero", m_rd, 0);
    xfer(5'h00, 1'b1, 32'h0000_8000);
    xfer(5'h04, 1'b0, 0);
    chk("R12 cmd read no cycle", m_low, 0);
    chk("R12 cmd read zero", m_rd, 0);
    xfer(5'h08, 1'b0, 0);
    chk("R12 addr read ack", m_ack, 1);

    // vector table: R3 R4 R5 R6 R7
    for (int v = 0; v < 7; v++) begin
      e = VEC[v];
      op = int'(e[19:18]); s = int'(e[17:16]); wv = int'(e[14:12]); h = int'(e[10:8]);
      b = e[7:0];
      xfer(5'h00, 1'b1, 32'h8000 | (s << 8) | (wv << 4) | h);
      rd_val = b;
      a = (op == 0) ? 5'h04 : ((op == 1) ? 5'h08 : 5'h0C);
      xfer(a, (op != 3), {24'h0, b});
      tot = s + wv + h + 3;
      chk($sformatf("R3 setup v%0d", v), m_pre, s + 1);
      chk($sformatf("R3 strobe v%0d", v), m_low, wv + 1);
      chk($sformatf("R3 hold v%0d", v), m_post, h + 1);
      chk($sformatf("R7 ack time v%0d", v), m_ack, tot + 1);
      chk($sformatf("R4 cle v%0d", v), m_cle, (op == 0) ? tot : 0);
      chk($sformatf("R4 ale v%0d", v), m_ale, (op == 1) ? tot : 0);
      chk($sformatf("R5 oe v%0d", v), m_oe, (op != 3) ? tot : 0);
      if (op != 3) chk($sformatf("R5 data v%0d", v), {31'h0, m_dq_ok}, 1);
      else         chk($sformatf("R6 read byte v%0d", v), m_rd, {24'h0, b});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule